// File: doc/BRIEF.md
# Cycle-Based Overcurrent Limiter

This block guards one switching power channel against overload. Once per switching period it receives a single-cycle tick, and with it a flag telling whether the current sensed while the low-side switch conducted lay above the limit. When the flag is set, the block holds off the next high-side turn-on (pulse skipping). It also tracks whether the overload keeps coming back and shuts the channel down if it does.

The first trip opens a grace window of eight switching periods. Trips inside that window only skip pulses. The eight periods after the grace window form a watch window. A trip there latches a fault that requests channel shutdown and holds power-good low. If the watch window passes without a trip, the limiter re-arms sixteen periods after the first trip. A latched fault is released only by a clear input, which the surrounding logic drives on a supply cycle or an enable toggle. A bypass input holds the limiter idle. It is used when the channel runs as a tracking rail whose current limit is turned off.

Top module: `oc_cycle_limiter`

## Requirements
- R1: After reset, hs_skip, fault_latched and limiting are all 0 and the limiter is idle.
- R2: On a clock with sw_tick=1 and oc_over=1 (no clear, no bypass), hs_skip is 1 from the next clock until the next tick. At each tick hs_skip takes the oc_over value of that tick, or 1 if a fault is latched.
- R3: A tick with oc_over=1 while idle is the first trip: limiting becomes 1 on the next clock.
- R4: Trips at ticks 1 to 8 after the first trip (the grace window) only skip pulses and never set fault_latched.
- R5: A trip at ticks 9 to 16 after the first trip sets fault_latched=1 and hs_skip=1, and clears limiting, on the next clock.
- R6: If ticks 9 to 16 carry no trip, limiting returns to 0 after tick 16, and a later trip opens a fresh grace window.
- R7: Cycles without sw_tick change no output, whatever oc_over does.
- R8: A latched fault holds fault_latched=1 and hs_skip=1 through any ticks and trips until clear_fault or lim_bypass.
- R9: clear_fault=1 returns the limiter to idle with all outputs 0 on the next clock from any state, with priority over a simultaneous tick.
- R10: While lim_bypass=1 the limiter stays idle with all outputs 0, trips are ignored, and a latched fault is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_tick | input | 1 | One-clock pulse per switching period |
| oc_over | input | 1 | Overcurrent compare result for the period, valid with sw_tick |
| clear_fault | input | 1 | Releases a latched fault and returns the limiter to idle |
| lim_bypass | input | 1 | Holds the limiter idle (limit turned off) |
| hs_skip | output | 1 | Inhibits the next high-side turn-on |
| fault_latched | output | 1 | Latched overcurrent fault: shutdown request and power-good force-low |
| limiting | output | 1 | Grace or watch window open |

## Verification
The assertions assume that sw_tick, oc_over, clear_fault and lim_bypass are synchronous to clk. They also assume that oc_over is only meaningful in a cycle where sw_tick is high; otherwise the limiter ignores it. The stimulus changes every input on the falling clock edge. Ticks are spaced three clocks apart, and oc_over is raised in the cycles between ticks to show that it has no effect there. The window boundaries are hit by counting ticks from the first trip. Trips fall on the last grace tick, the first watch tick and the last watch tick, and a new trip follows straight after a re-arm.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

   typedef enum logic [1:0] {
      OCL_IDLE  = 2'd0,
      OCL_GRACE = 2'd1,
      OCL_WATCH = 2'd2,
      OCL_LATCH = 2'd3
   } ocl_state_e;

   function automatic logic ocl_is_window(input ocl_state_e s);
      return (s == OCL_GRACE) || (s == OCL_WATCH);
   endfunction

endpackage

// File: rtl/ocl_window_cnt.sv
module ocl_window_cnt #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (clr)  count <= '0;
      else if (inc)  count <= count + 1'b1;
   end

   // R6: the elapsed-tick count never runs past the end of the watch window
   assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(LIMIT));

endmodule

// File: rtl/ocl_trip_fsm.sv
module ocl_trip_fsm
   import ocl_pkg::*;
#(
   parameter int unsigned GRACE_TICKS = 8,
   parameter int unsigned WATCH_TICKS = 8,
   parameter int unsigned CW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          oc_hit,
   input  logic          flush,
   input  logic [CW-1:0] elapsed,
   output ocl_state_e    state,
   output logic          cnt_clr,
   output logic          cnt_inc,
   output logic          locked_nxt
);

   localparam int unsigned TOTAL = GRACE_TICKS + WATCH_TICKS;
   localparam logic [CW:0] GRACE_L = (CW+1)'(GRACE_TICKS);
   localparam logic [CW:0] TOTAL_L = (CW+1)'(TOTAL);

   ocl_state_e  nxt;
   logic [CW:0] e_nxt;

   assign e_nxt = {1'b0, elapsed} + 1'b1;

   always_comb begin
      nxt     = state;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      if (flush) begin
         nxt     = OCL_IDLE;
         cnt_clr = 1'b1;
      end else if (tick) begin
         unique case (state)
            OCL_IDLE: begin
               if (oc_hit) begin
                  nxt     = OCL_GRACE;
                  cnt_clr = 1'b1;
               end
            end
            OCL_GRACE, OCL_WATCH: begin
               if (oc_hit && (e_nxt > GRACE_L)) begin
                  nxt     = OCL_LATCH;
                  cnt_clr = 1'b1;
               end else if (e_nxt == TOTAL_L) begin
                  nxt     = OCL_IDLE;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
                  nxt     = (e_nxt >= GRACE_L) ? OCL_WATCH : OCL_GRACE;
               end
            end
            OCL_LATCH: nxt = OCL_LATCH;
            default:   nxt = OCL_IDLE;
         endcase
      end
   end

   assign locked_nxt = (nxt == OCL_LATCH);

   always_ff @(posedge clk) begin
      if (!rst_n) state <= OCL_IDLE;
      else        state <= nxt;
   end

   // R4: a trip inside the grace window never latches the fault directly
   assert_grace_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == OCL_GRACE) |=> (state != OCL_LATCH));

   // R5: a latched fault stays latched unless flushed
   assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == OCL_LATCH) && !flush |=> (state == OCL_LATCH));

   // R9: a flush always lands in idle
   assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (state == OCL_IDLE));

endmodule

// File: rtl/ocl_skip_stage.sv
module ocl_skip_stage #(
   parameter bit HOLD_SKIP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic oc_hit,
   input  logic flush,
   input  logic locked_nxt,
   output logic skip
);

   logic skip_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      skip_q <= 1'b0;
      else if (flush)  skip_q <= 1'b0;
      else if (tick)   skip_q <= oc_hit | locked_nxt;
   end

   generate
      if (HOLD_SKIP) begin : g_hold
         assign skip = skip_q;
      end else begin : g_immediate
         assign skip = (tick & oc_hit & ~flush) | skip_q;
      end
   endgenerate

   // R2: a trip seen at a tick blocks the next high-side turn-on
   assert_trip_skips_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && oc_hit && !flush |=> skip);

endmodule

// File: rtl/oc_cycle_limiter.sv
module oc_cycle_limiter
   import ocl_pkg::*;
#(
   parameter int unsigned GRACE_TICKS = 8,
   parameter int unsigned WATCH_TICKS = 8,
   parameter bit          HOLD_SKIP   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_tick,
   input  logic oc_over,
   input  logic clear_fault,
   input  logic lim_bypass,
   output logic hs_skip,
   output logic fault_latched,
   output logic limiting
);

   localparam int unsigned TOTAL = GRACE_TICKS + WATCH_TICKS;
   localparam int unsigned CW    = $clog2(TOTAL + 1);

   initial begin
      assert (GRACE_TICKS >= 1) else $error("GRACE_TICKS must be at least 1");
      assert (WATCH_TICKS >= 1) else $error("WATCH_TICKS must be at least 1");
   end

   logic          flush;
   logic          oc_hit;
   logic          cnt_clr;
   logic          cnt_inc;
   logic          locked_nxt;
   logic [CW-1:0] elapsed;
   ocl_state_e    state;

   assign flush  = clear_fault | lim_bypass;
   assign oc_hit = oc_over & ~lim_bypass;

   ocl_window_cnt #(.LIMIT(TOTAL), .CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .count (elapsed)
   );

   ocl_trip_fsm #(
      .GRACE_TICKS (GRACE_TICKS),
      .WATCH_TICKS (WATCH_TICKS),
      .CW          (CW)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sw_tick),
      .oc_hit     (oc_hit),
      .flush      (flush),
      .elapsed    (elapsed),
      .state      (state),
      .cnt_clr    (cnt_clr),
      .cnt_inc    (cnt_inc),
      .locked_nxt (locked_nxt)
   );

   ocl_skip_stage #(.HOLD_SKIP(HOLD_SKIP)) u_skip (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sw_tick),
      .oc_hit     (oc_hit),
      .flush      (flush),
      .locked_nxt (locked_nxt),
      .skip       (hs_skip)
   );

   assign fault_latched = (state == OCL_LATCH);
   assign limiting      = ocl_is_window(state);

   // R3: a window only opens on a tick that carries a trip
   assert_window_opens_on_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(limiting) |-> $past(sw_tick && oc_over));

   // R7: without a tick or a flush, no output moves
   assert_quiet_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_tick && !clear_fault && !lim_bypass |=>
         $stable(limiting) && $stable(fault_latched) && (HOLD_SKIP ? $stable(hs_skip) : 1'b1));

   // R8: a latched fault keeps skipping pulses until released
   assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched && !clear_fault && !lim_bypass |=> fault_latched && hs_skip);

   // R10: bypass keeps every output low
   assert_bypass_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lim_bypass |=> !hs_skip && !fault_latched && !limiting);

endmodule

// File: tb/test_oc_cycle_limiter.sv
`timescale 1ns/1ps
module test_oc_cycle_limiter;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_tick = 1'b0, oc_over = 1'b0, clear_fault = 1'b0, lim_bypass = 1'b0;
   logic hs_skip, fault_latched, limiting;

   always #2.5 clk = ~clk;

   oc_cycle_limiter i_oc_cycle_limiter (
      .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .oc_over(oc_over),
      .clear_fault(clear_fault), .lim_bypass(lim_bypass),
      .hs_skip(hs_skip), .fault_latched(fault_latched), .limiting(limiting)
   );

   typedef struct {
      logic  skip;
      logic  fault;
      logic  lim;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model: 0 idle, 1 window, 2 latched; m_el = ticks since first trip
   int   m_st = 0;
   int   m_el = 0;
   logic m_skip = 1'b0;

   task automatic step(input logic t, input logic oc, input logic clr,
                       input logic byp, input string tag);
      exp_t e;
      @(negedge clk);
      sw_tick = t; oc_over = oc; clear_fault = clr; lim_bypass = byp;
      if (clr || byp) begin
         m_st = 0; m_el = 0; m_skip = 1'b0;
      end else if (t) begin
         if (m_st == 0) begin
            m_skip = oc;
            if (oc) begin m_st = 1; m_el = 0; end
         end else if (m_st == 1) begin
            m_el = m_el + 1;
            if (oc && m_el > 8) begin
               m_st = 2; m_skip = 1'b1;
            end else begin
               m_skip = oc;
               if (m_el == 16) begin m_st = 0; m_el = 0; end
            end
         end else begin
            m_skip = 1'b1;
         end
      end
      e.skip = m_skip; e.fault = (m_st == 2); e.lim = (m_st == 1); e.tag = tag;
      exp_q.push_back(e);
   endtask

   // one switching period: tick, then two clocks where oc_over must be ignored (R7)
   task automatic period(input logic oc, input string tag);
      step(1'b1, oc, 1'b0, 1'b0, tag);
      step(1'b0, 1'b1, 1'b0, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (hs_skip !== e.skip || fault_latched !== e.fault || limiting !== e.lim) begin
               n_fail++;
               $display("FAIL %s: got skip=%b fault=%b lim=%b expected skip=%b fault=%b lim=%b",
                        e.tag, hs_skip, fault_latched, limiting, e.skip, e.fault, e.lim);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (hs_skip !== 1'b0 || fault_latched !== 1'b0 || limiting !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: got skip=%b fault=%b lim=%b expected 0 0 0",
                  hs_skip, fault_latched, limiting);
      end
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, "R1");

      // R7: trips without a tick do nothing
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R7");

      // R3/R2: first trip; R4: trips at ticks 3 and 8; R6: clean watch, re-arm
      period(1'b1, "R3");
      for (int k = 1; k <= 16; k++)
         period((k == 3) || (k == 8), (k <= 8) ? "R4" : "R6");
      period(1'b0, "R6");

      // R5: trip at tick 9 latches; R8: holds; R9: clear
      period(1'b1, "R3");
      for (int k = 1; k <= 8; k++) period(1'b0, "R4");
      period(1'b1, "R5");
      period(1'b0, "R8");
      period(1'b1, "R8");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R9");

      // R5: trip at tick 16 still latches; R9: clear wins over tick with trip
      period(1'b1, "R3");
      for (int k = 1; k <= 15; k++) period(1'b0, "R6");
      period(1'b1, "R5");
      step(1'b1, 1'b1, 1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R9");

      // R6: re-arm then immediate new trip opens a fresh grace window
      period(1'b1, "R3");
      for (int k = 1; k <= 16; k++) period(1'b0, "R6");
      period(1'b1, "R6");
      period(1'b1, "R6");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R9");

      // R10: bypass ignores trips and drops a latched fault
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b0, 1'b1, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
      period(1'b1, "R3");
      for (int k = 1; k <= 8; k++) period(1'b0, "R4");
      period(1'b1, "R5");
      step(1'b1, 1'b1, 1'b0, 1'b1, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R10");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule